// File: doc/BRIEF.md
# DS3 C-bit Parity Frame Generator

This block produces a serial DS3 line stream in C-bit parity format, one bit per clock. Each 4760-bit frame is made of seven subframes. A subframe holds eight 85-bit blocks, and each block is one overhead bit followed by 84 payload bits. The generator walks through these positions on its own. It requests a payload bit from an upstream source ahead of every payload position. It fills every overhead position from a fixed map:

- framing patterns (F and M bits);
- a pair of remote-defect (X) bits;
- path parity (P) and C-bit parity (CP) bits, which it computes itself;
- the channel bits: far-end alarm, data link, user data link and far-end block error, each taken from its own input pin.

The block is meant to feed a line encoder. The upstream payload source watches `payload_req` and puts a bit on `payload_in` in the next cycle. Downstream logic can align to the frame using `frame_start` and the three position outputs, which always describe the bit currently on `line_out`.

Top module: `ds3cb_framegen`

## Requirements
- R1: A frame is 4760 line bits long. `sf_idx` (0..6), `blk_idx` (0..7) and `bit_idx` (0..84, where 0 is the overhead bit of a block) describe the bit on `line_out` and advance by one position per clock. `frame_start` is 1 exactly when `line_out` carries position sf 0, block 0, bit 0.
- R2: `payload_req` is 1 in a cycle exactly when the following line position is a payload bit, which gives 4704 requests per frame. The value on `payload_in` in the cycle after a request appears on `line_out` one clock later, and payload order is preserved.
- R3: The overhead bits of blocks 1 and 7 are 1, and those of blocks 3 and 5 are 0, in every subframe.
- R4: The overhead bit of block 0 is 0 in subframes 4 and 6, and 1 in subframe 5.
- R5: The overhead bit of block 0 in subframes 0 and 1 equals `x_in`.
- R6: The overhead bit of block 0 in subframes 2 and 3 equals the XOR of all 4704 payload bits of the previous frame. It is 0 in the first frame after reset.
- R7: The overhead bits of blocks 2, 4 and 6 in subframe 2 carry the same value as the R6 bits.
- R8: In subframe 0, blocks 2 and 4 carry 1 and block 6 carries `feac_in`. In subframe 1, block 4 carries 1.
- R9: In subframe 1, blocks 2 and 6 carry `udl_in`. Blocks 2, 4 and 6 carry `febe_in` in subframe 3, `dl_in` in subframe 4, and `udl_in` in subframes 5 and 6. Each channel input is sampled in the cycle before its line bit appears.
- R10: While `rst` is 1 (synchronous), `line_out`, `frame_start` and `payload_req` are 0, and the parity state is cleared. The first clock with `rst` at 0 starts position sf 0, block 0, bit 0 of a new frame, and that bit reaches `line_out` after two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous reset, active high |
| payload_req | output | 1 | Next line position is payload; supply a bit next cycle |
| payload_in | input | 1 | Payload bit, valid in the cycle after a request |
| x_in | input | 1 | Remote-defect bit value (1 = no defect) |
| feac_in | input | 1 | Far-end alarm channel bit |
| dl_in | input | 1 | Data link channel bit |
| udl_in | input | 1 | User data link channel bit |
| febe_in | input | 1 | Far-end block error bit |
| line_out | output | 1 | Serial DS3 line bit |
| frame_start | output | 1 | Line bit is the first bit of a frame |
| sf_idx | output | 3 | Subframe of the line bit (0..6) |
| blk_idx | output | 3 | Block within the subframe (0..7) |
| bit_idx | output | 7 | Position within the block, 0 = overhead |

## Verification
The hardest situation to reach is a reset that lands in the middle of a frame. At that point the parity accumulator holds a partial sum and the latched parity from the previous frame is 1. Only then does a failure to clear the parity state show up, as a wrong P bit in the first frame after reset. The stimulus runs three full frames with payload patterns whose parities are 0, 0 and 1. It then resets about 2000 bits into a mixed-pattern frame and checks the parity bits of the next frame and of the one after it. The channel inputs change only at frame boundaries, using a different bit code for each frame, so that every channel position is seen at both 0 and 1. The payload input is driven to 1 at overhead slots, which shows that the fixed 0 bits ignore it.

// File: rtl/ds3cb_pkg.sv
package ds3cb_pkg;

  typedef enum logic [3:0] {
    SRC_PAY, SRC_ONE, SRC_ZERO, SRC_X, SRC_PAR,
    SRC_FEAC, SRC_UDL, SRC_FEBE, SRC_DL
  } ds3cb_src_e;

  // Source of the overhead bit in block blk of subframe sf.
  function automatic ds3cb_src_e ds3cb_oh_src(input logic [31:0] sf,
                                              input logic [31:0] blk);
    logic [31:0] c;
    c = (blk >> 1) - 32'd1;
    case (blk)
      32'd0: begin
        if (sf < 32'd2)       return SRC_X;
        else if (sf < 32'd4)  return SRC_PAR;
        else if (sf == 32'd5) return SRC_ONE;
        else                  return SRC_ZERO;
      end
      32'd1, 32'd7: return SRC_ONE;
      32'd3, 32'd5: return SRC_ZERO;
      default: begin
        case (sf)
          32'd0:   return (c == 32'd2) ? SRC_FEAC : SRC_ONE;
          32'd1:   return (c == 32'd1) ? SRC_ONE : SRC_UDL;
          32'd2:   return SRC_PAR;
          32'd3:   return SRC_FEBE;
          32'd4:   return SRC_DL;
          default: return SRC_UDL;
        endcase
      end
    endcase
  endfunction

  function automatic logic ds3cb_pick(input ds3cb_src_e s, input logic pay,
                                      input logic x, input logic par,
                                      input logic feac, input logic udl,
                                      input logic febe, input logic dl);
    case (s)
      SRC_PAY:  return pay;
      SRC_ONE:  return 1'b1;
      SRC_X:    return x;
      SRC_PAR:  return par;
      SRC_FEAC: return feac;
      SRC_UDL:  return udl;
      SRC_FEBE: return febe;
      SRC_DL:   return dl;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ds3cb_poscnt.sv
module ds3cb_poscnt #(
  parameter int PAY_BITS  = 84,
  parameter int BLOCKS    = 8,
  parameter int SUBFRAMES = 7,
  localparam int BW = $clog2(PAY_BITS + 1),
  localparam int KW = $clog2(BLOCKS),
  localparam int SW = $clog2(SUBFRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [BW-1:0] bit_o,
  output logic [KW-1:0] blk_o,
  output logic [SW-1:0] sf_o
);

  logic bit_wrap, blk_wrap, sf_wrap;
  assign bit_wrap = (bit_o == BW'(PAY_BITS));
  assign blk_wrap = (blk_o == KW'(BLOCKS - 1));
  assign sf_wrap  = (sf_o == SW'(SUBFRAMES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o <= '0;
      blk_o <= '0;
      sf_o  <= '0;
    end else if (!bit_wrap) begin
      bit_o <= bit_o + 1'b1;
    end else begin
      bit_o <= '0;
      if (!blk_wrap) begin
        blk_o <= blk_o + 1'b1;
      end else begin
        blk_o <= '0;
        sf_o  <= sf_wrap ? '0 : sf_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ds3cb_parity.sv
module ds3cb_parity (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic din,
  input  logic close,
  output logic par_o
);

  logic acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= 1'b0;
      par_o <= 1'b0;
    end else if (take) begin
      if (close) begin
        par_o <= acc ^ din;
        acc   <= 1'b0;
      end else begin
        acc <= acc ^ din;
      end
    end
  end

endmodule

// File: rtl/ds3cb_framegen.sv
module ds3cb_framegen
  import ds3cb_pkg::*;
#(
  parameter int PAY_BITS  = 84,
  parameter int BLOCKS    = 8,
  parameter int SUBFRAMES = 7,
  localparam int BW = $clog2(PAY_BITS + 1),
  localparam int KW = $clog2(BLOCKS),
  localparam int SW = $clog2(SUBFRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          payload_req,
  input  logic          payload_in,
  input  logic          x_in,
  input  logic          feac_in,
  input  logic          dl_in,
  input  logic          udl_in,
  input  logic          febe_in,
  output logic          line_out,
  output logic          frame_start,
  output logic [SW-1:0] sf_idx,
  output logic [KW-1:0] blk_idx,
  output logic [BW-1:0] bit_idx
);

  // Stage A: position whose payload is being requested.
  logic [BW-1:0] a_bit;
  logic [KW-1:0] a_blk;
  logic [SW-1:0] a_sf;

  ds3cb_poscnt #(.PAY_BITS(PAY_BITS), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES))
    u_pos (.clk(clk), .rst(rst), .bit_o(a_bit), .blk_o(a_blk), .sf_o(a_sf));

  assign payload_req = (a_bit != '0);

  // Stage B: the position whose line value is formed this cycle.
  logic          b_vld;
  logic [BW-1:0] b_bit;
  logic [KW-1:0] b_blk;
  logic [SW-1:0] b_sf;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_vld <= 1'b0;
      b_bit <= '0;
      b_blk <= '0;
      b_sf  <= '0;
    end else begin
      b_vld <= 1'b1;
      b_bit <= a_bit;
      b_blk <= a_blk;
      b_sf  <= a_sf;
    end
  end

  logic b_is_pay, b_frame_end, b_origin, par_prev, b_val;
  ds3cb_src_e b_src;

  assign b_is_pay    = b_vld && (b_bit != '0);
  assign b_frame_end = b_is_pay && (b_bit == BW'(PAY_BITS)) &&
                       (b_blk == KW'(BLOCKS - 1)) &&
                       (b_sf == SW'(SUBFRAMES - 1));
  assign b_origin    = b_vld && (b_bit == '0) && (b_blk == '0) && (b_sf == '0);

  ds3cb_parity u_par (
    .clk(clk), .rst(rst), .take(b_is_pay), .din(payload_in),
    .close(b_frame_end), .par_o(par_prev)
  );

  always_comb begin
    b_src = b_is_pay ? SRC_PAY : ds3cb_oh_src(32'(b_sf), 32'(b_blk));
    b_val = ds3cb_pick(b_src, payload_in, x_in, par_prev, feac_in,
                       udl_in, febe_in, dl_in);
  end

  // Output stage.
  logic o_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld       <= 1'b0;
      line_out    <= 1'b0;
      frame_start <= 1'b0;
      sf_idx      <= '0;
      blk_idx     <= '0;
      bit_idx     <= '0;
    end else begin
      o_vld       <= b_vld;
      line_out    <= b_vld && b_val;
      frame_start <= b_origin;
      sf_idx      <= b_sf;
      blk_idx     <= b_blk;
      bit_idx     <= b_bit;
    end
  end

endmodule

// File: rtl/ds3cb_framegen_chk.sv
module ds3cb_framegen_chk #(
  parameter int PAY_BITS  = 84,
  parameter int BLOCKS    = 8,
  parameter int SUBFRAMES = 7,
  localparam int BW = $clog2(PAY_BITS + 1),
  localparam int KW = $clog2(BLOCKS),
  localparam int SW = $clog2(SUBFRAMES)
) (
  input logic          clk,
  input logic          rst,
  input logic          payload_req,
  input logic          line_out,
  input logic          frame_start,
  input logic [SW-1:0] sf_idx,
  input logic [KW-1:0] blk_idx,
  input logic [BW-1:0] bit_idx,
  input logic          b_is_pay,
  input logic          o_vld
);

  logic oh0, p_cap;
  assign oh0 = o_vld && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) p_cap <= 1'b0;
    else if (oh0 && sf_idx == SW'(2) && blk_idx == '0) p_cap <= line_out;
  end

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!line_out && !frame_start && !payload_req && !o_vld));

  a_r1_bit_step: assert property (@(posedge clk) disable iff (rst)
    (o_vld && bit_idx != BW'(PAY_BITS)) |=> (bit_idx == $past(bit_idx) + 1'b1));

  a_r1_start_origin: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (sf_idx == '0 && blk_idx == '0 && bit_idx == '0));

  a_r2_req_then_payload: assert property (@(posedge clk) disable iff (rst)
    payload_req |=> b_is_pay);

  a_r2_noreq_no_payload: assert property (@(posedge clk) disable iff (rst)
    !payload_req |=> !b_is_pay);

  a_r3_f_one: assert property (@(posedge clk) disable iff (rst)
    (oh0 && (blk_idx == KW'(1) || blk_idx == KW'(7))) |-> line_out);

  a_r3_f_zero: assert property (@(posedge clk) disable iff (rst)
    (oh0 && (blk_idx == KW'(3) || blk_idx == KW'(5))) |-> !line_out);

  a_r4_m_pattern: assert property (@(posedge clk) disable iff (rst)
    (oh0 && blk_idx == '0 && sf_idx >= SW'(4)) |-> (line_out == (sf_idx == SW'(5))));

  a_r6_p_pair: assert property (@(posedge clk) disable iff (rst)
    (oh0 && blk_idx == '0 && sf_idx == SW'(3)) |-> (line_out == p_cap));

  a_r7_cp_matches_p: assert property (@(posedge clk) disable iff (rst)
    (oh0 && sf_idx == SW'(2) && (blk_idx == KW'(2) || blk_idx == KW'(4) ||
     blk_idx == KW'(6))) |-> (line_out == p_cap));

  a_r8_fixed_ones: assert property (@(posedge clk) disable iff (rst)
    (oh0 && ((sf_idx == '0 && (blk_idx == KW'(2) || blk_idx == KW'(4))) ||
             (sf_idx == SW'(1) && blk_idx == KW'(4)))) |-> line_out);

endmodule

bind ds3cb_framegen ds3cb_framegen_chk #(
  .PAY_BITS(PAY_BITS), .BLOCKS(BLOCKS), .SUBFRAMES(SUBFRAMES)
) u_chk (
  .clk(clk), .rst(rst), .payload_req(payload_req), .line_out(line_out),
  .frame_start(frame_start), .sf_idx(sf_idx), .blk_idx(blk_idx),
  .bit_idx(bit_idx), .b_is_pay(b_is_pay), .o_vld(o_vld)
);

// File: tb/ds3cb_framegen_tb.sv
module ds3cb_framegen_tb;

  localparam int FRAME = 4760;
  localparam int PAYN  = 4704;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic payload_req, payload_in, x_in, feac_in, dl_in, udl_in, febe_in;
  logic line_out, frame_start;
  logic [2:0] sf_idx, blk_idx;
  logic [6:0] bit_idx;

  always #10 clk = ~clk;  // 50 MHz

  ds3cb_framegen u_dut (
    .clk(clk), .rst(rst), .payload_req(payload_req), .payload_in(payload_in),
    .x_in(x_in), .feac_in(feac_in), .dl_in(dl_in), .udl_in(udl_in),
    .febe_in(febe_in), .line_out(line_out), .frame_start(frame_start),
    .sf_idx(sf_idx), .blk_idx(blk_idx), .bit_idx(bit_idx)
  );

  int checks = 0, failures = 0;
  int n, pidx, dframe, ohf;
  bit pend, acc_m, par_m;
  bit q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic bit pay_pat(input int f, input int i);
    case (f % 4)
      0: return 1'b0;
      1: return 1'b1;
      2: return (i == 0);
      default: return ((i * 5 + i / 7) % 3) == 1;
    endcase
  endfunction

  task automatic set_oh(input int f);
    int code;
    code = f * 5 + 3;
    x_in    = code[0];
    feac_in = code[1];
    dl_in   = code[2];
    udl_in  = code[3];
    febe_in = code[4];
  endtask

  // Expected overhead bit and the requirement it belongs to.
  task automatic exp_oh(input int sf, input int blk, output bit v, output string r);
    int c;
    if (blk == 1 || blk == 7) begin v = 1; r = "R3"; end
    else if (blk == 3 || blk == 5) begin v = 0; r = "R3"; end
    else if (blk == 0) begin
      if (sf < 2) begin v = x_in; r = "R5"; end
      else if (sf < 4) begin v = par_m; r = "R6"; end
      else begin v = (sf == 5); r = "R4"; end
    end else begin
      c = blk / 2;  // 1, 2, 3
      case (sf)
        0: begin v = (c == 3) ? feac_in : 1'b1; r = "R8"; end
        1: begin
          if (c == 2) begin v = 1; r = "R8"; end
          else begin v = udl_in; r = "R9"; end
        end
        2: begin v = par_m; r = "R7"; end
        3: begin v = febe_in; r = "R9"; end
        4: begin v = dl_in; r = "R9"; end
        default: begin v = udl_in; r = "R9"; end
      endcase
    end
  endtask

  // Monitor: compares the line against the scoreboard.
  task automatic monitor_step();
    int mpos, sf, blk, b;
    bit v;
    string r;
    if (n == 1) begin
      chk(line_out == 0 && frame_start == 0, "R10", int'(line_out), 0);
    end else if (n >= 2) begin
      mpos = (n - 2) % FRAME;
      sf = mpos / 680;
      blk = (mpos % 680) / 85;
      b = mpos % 85;
      chk(frame_start == (mpos == 0), "R1", int'(frame_start), int'(mpos == 0));
      chk(int'(sf_idx) == sf && int'(blk_idx) == blk && int'(bit_idx) == b, "R1",
          int'(sf_idx) * 1000 + int'(blk_idx) * 100 + int'(bit_idx),
          sf * 1000 + blk * 100 + b);
      if (b != 0) begin
        if (q.size() == 0) begin
          chk(0, "R2", int'(line_out), -1);
          v = 0;
        end else begin
          v = q.pop_front();
        end
        chk(line_out == v, "R2", int'(line_out), int'(v));
        acc_m ^= v;
        if (mpos == FRAME - 1) begin
          par_m = acc_m;
          acc_m = 0;
        end
      end else begin
        exp_oh(sf, blk, v, r);
        chk(line_out == v, r, int'(line_out), int'(v));
      end
      if (mpos == FRAME - 2) begin
        ohf++;
        set_oh(ohf);
      end
    end
  endtask

  // Driver: answers requests and pushes the expected payload.
  task automatic driver_step();
    bit v;
    chk(payload_req == (((n % FRAME) % 85) != 0), "R2",
        int'(payload_req), int'(((n % FRAME) % 85) != 0));
    if (pend) begin
      v = pay_pat(dframe, pidx);
      payload_in = v;
      q.push_back(v);
      pidx++;
      if (pidx == PAYN) begin
        pidx = 0;
        dframe++;
      end
    end else begin
      payload_in = 1'b1;  // ignored at overhead slots
    end
    pend = payload_req;
  endtask

  task automatic do_reset(input int df, input int of);
    @(negedge clk);
    rst = 1'b1;
    payload_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(line_out == 0 && frame_start == 0 && payload_req == 0, "R10",
          int'(line_out) + 2 * int'(frame_start) + 4 * int'(payload_req), 0);
    end
    n = 0; pend = 0; q.delete(); acc_m = 0; par_m = 0;
    pidx = 0; dframe = df; ohf = of;
    set_oh(ohf);
    rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n++;
      monitor_step();
      driver_step();
    end
  endtask

  initial begin
    payload_in = 1'b0;
    set_oh(0);
    do_reset(0, 0);
    run(3 * FRAME + 2000);   // parities 0, 0, 1, then part of a mixed frame
    do_reset(2, 7);          // mid-frame reset: parity must restart at 0 (R6, R10)
    run(3 * FRAME + 200);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (R1)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule